// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This unit watches a live calendar, handed in as two packed 32-bit time words, and compares it against a programmed alarm time. The comparison runs once per one-second tick strobe. Each of the two alarm words has its own 32-bit bitwise compare mask. Any bit inside any field can be left out of the match, and a mask word of all zeros drops its whole word. On a qualified match the unit raises a level wake-up interrupt. The interrupt stays high until software clears it.

Software programs the unit through a simple write port. The control word carries single-cycle commands: arm the alarm, disarm it, clear the wake flag and set the wake flag. The mode word enables wake and picks what the surrounding timekeeper does after a match. It can ask for the counters to be cleared, let counting continue, or hold counting while the interrupt is pending. The time counters themselves live outside this block.

Top module: `cal_alarm_unit`

## Requirements
- R1: After reset `irq_o`, `cnt_clear_o` and `cnt_hold_o` are 0, the alarm is disarmed, and all alarm, mask and mode registers are 0.
- R2: The low time word packs seconds in bits 7:0, minutes in 15:8, hours in 23:16 and day in 31:24. With the full low mask set, a tick on which every low bit equals the low alarm word raises `irq_o` on the following clock edge. A single differing bit prevents it.
- R3: A mask bit of 1 makes that alarm bit take part in the match, and a mask bit of 0 ignores it. A mask word of all zeros ignores its whole word, so with both masks zero every qualified tick matches.
- R4: The high time word packs month in bits 7:0, year in 15:8 and weekday in 23:16. It is compared under its own mask in the same way as the low word.
- R5: A match is evaluated only in a cycle where `tick_i` is high. Equal fields without a tick never raise `irq_o`.
- R6: Register offsets are: control 0x00, mode 0x04, low alarm 0x0C, high alarm 0x10, low mask 0x14, high mask 0x18. Control bit 2 arms the alarm and control bit 3 disarms it, with disarm winning if both are written. A disarmed alarm raises no interrupt on a match.
- R7: Mode bit 1 enables wake. With it clear, a match raises no interrupt.
- R8: `irq_o` is a level. It stays high across later cycles and ticks until a control write with bit 3 (disarm) or bit 8 (wake-flag clear) drops it on that write's clock edge.
- R9: A control write with bit 9 sets the wake flag on that write's edge, whether or not the alarm is armed.
- R10: With mode bit 2 set, each fired match drives `cnt_clear_o` high for exactly one cycle, in the same cycle in which `irq_o` is updated.
- R11: `cnt_hold_o` is high while `irq_o` is high and mode bit 3 (continue after wake) is clear. Otherwise it is low.
- R12: A clear command in the same cycle as a firing tick wins, and `irq_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| now_lo_i | input | 32 | Live seconds, minutes, hours and day |
| now_hi_i | input | 32 | Live month, year and weekday |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register byte offset |
| wr_data_i | input | 32 | Register write data |
| irq_o | output | 1 | Wake-up interrupt level |
| cnt_clear_o | output | 1 | One-cycle request to clear the time counters |
| cnt_hold_o | output | 1 | Request to hold counting while the interrupt is pending |

## Verification
Every result of this block comes from one register stage. A register write takes effect on the clock edge that samples it. The interrupt, the counter-clear pulse and the hold level all reflect a tick or command on the edge that samples that tick or command. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. A check on the counter-clear pulse also samples one further falling edge to confirm the pulse has already dropped.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int MODE_W  = 4;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_ALM_LO = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_ALM_HI = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_MSK_LO = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_MSK_HI = 8'h18;

  localparam int CB_ARM      = 2;
  localparam int CB_DISARM   = 3;
  localparam int CB_WAKE_CLR = 8;
  localparam int CB_WAKE_SET = 9;

  localparam int MB_WAKE_EN  = 1;
  localparam int MB_RST_CNT  = 2;
  localparam int MB_CONTINUE = 3;

  typedef struct packed {
    logic arm;
    logic disarm;
    logic wclr;
    logic wset;
  } cmd_t;

  function automatic logic masked_eq(input logic [DATA_W-1:0] live,
                                     input logic [DATA_W-1:0] alarm,
                                     input logic [DATA_W-1:0] mask);
    return ((live ^ alarm) & mask) == '0;
  endfunction
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] alm_lo_o,
  output logic [DATA_W-1:0] alm_hi_o,
  output logic [DATA_W-1:0] msk_lo_o,
  output logic [DATA_W-1:0] msk_hi_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              armed_o,
  output cmd_t              cmd_o
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en_i && (wr_addr_i == OFS_CTRL);

  always_comb begin
    cmd_o.arm    = ctrl_wr && wr_data_i[CB_ARM];
    cmd_o.disarm = ctrl_wr && wr_data_i[CB_DISARM];
    cmd_o.wclr   = ctrl_wr && wr_data_i[CB_WAKE_CLR];
    cmd_o.wset   = ctrl_wr && wr_data_i[CB_WAKE_SET];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alm_lo_o <= '0;
      alm_hi_o <= '0;
      msk_lo_o <= '0;
      msk_hi_o <= '0;
      mode_o   <= '0;
      armed_o  <= 1'b0;
    end else begin
      if (wr_en_i) begin
        case (wr_addr_i)
          OFS_MODE:   mode_o   <= wr_data_i[MODE_W-1:0];
          OFS_ALM_LO: alm_lo_o <= wr_data_i;
          OFS_ALM_HI: alm_hi_o <= wr_data_i;
          OFS_MSK_LO: msk_lo_o <= wr_data_i;
          OFS_MSK_HI: msk_hi_o <= wr_data_i;
          default: ;
        endcase
      end
      if (cmd_o.disarm)   armed_o <= 1'b0;
      else if (cmd_o.arm) armed_o <= 1'b1;
    end
  end

  // R6: a disarm command always leaves the alarm disarmed
  p_disarm_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o.disarm |=> !armed_o);
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
#(
  parameter int N_WORDS = 2
) (
  input  logic [N_WORDS-1:0][DATA_W-1:0] live_i,
  input  logic [N_WORDS-1:0][DATA_W-1:0] alarm_i,
  input  logic [N_WORDS-1:0][DATA_W-1:0] mask_i,
  output logic                           hit_o
);
  logic [N_WORDS-1:0] word_hit;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    assign word_hit[w] = masked_eq(live_i[w], alarm_i[w], mask_i[w]);

    // R3: an all-zero mask word never blocks the match
    always_comb begin
      if (mask_i[w] == '0)
        p_zero_mask_r3: assert (word_hit[w]);
    end
  end

  assign hit_o = &word_hit;
endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag
  import cal_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  cmd_t              cmd_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              irq_o,
  output logic              cnt_clear_o,
  output logic              cnt_hold_o
);
  logic clr_evt;
  assign clr_evt = cmd_i.disarm || cmd_i.wclr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o       <= 1'b0;
      cnt_clear_o <= 1'b0;
    end else begin
      if (clr_evt)                    irq_o <= 1'b0;
      else if (fire_i || cmd_i.wset)  irq_o <= 1'b1;
      cnt_clear_o <= fire_i && !clr_evt && mode_i[MB_RST_CNT];
    end
  end

  assign cnt_hold_o = irq_o && !mode_i[MB_CONTINUE];

  // R12 / R8: a clear command always leaves the flag low
  p_clear_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !irq_o);
  // R8: the level holds while no clear command arrives
  p_level_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_evt) |=> irq_o);
  // R5: no fire and no set command means no rise
  p_no_src_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !fire_i && !cmd_i.wset) |=> !irq_o);
  // R10: counter-clear pulse only with the flag, one cycle wide without a new fire
  p_pulse_with_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear_o |-> irq_o);
  p_pulse_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clear_o && !fire_i) |=> !cnt_clear_o);
  // R11: hold only with a pending flag
  p_hold_needs_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_hold_o |-> irq_o);
endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
  import cal_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] now_lo_i,
  input  logic [DATA_W-1:0] now_hi_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              irq_o,
  output logic              cnt_clear_o,
  output logic              cnt_hold_o
);
  logic [DATA_W-1:0] alm_lo, alm_hi, msk_lo, msk_hi;
  logic [MODE_W-1:0] mode;
  logic              armed;
  cmd_t              cmd;
  logic              hit;
  logic              fire;

  cal_alarm_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .alm_lo_o(alm_lo), .alm_hi_o(alm_hi), .msk_lo_o(msk_lo), .msk_hi_o(msk_hi),
    .mode_o(mode), .armed_o(armed), .cmd_o(cmd)
  );

  cal_alarm_match #(.N_WORDS(2)) u_match (
    .live_i({now_hi_i, now_lo_i}),
    .alarm_i({alm_hi, alm_lo}),
    .mask_i({msk_hi, msk_lo}),
    .hit_o(hit)
  );

  assign fire = tick_i && armed && mode[MB_WAKE_EN] && hit;

  cal_alarm_flag u_flag (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .cmd_i(cmd), .mode_i(mode),
    .irq_o(irq_o), .cnt_clear_o(cnt_clear_o), .cnt_hold_o(cnt_hold_o)
  );

  // R6 / R7 / R9: a rise comes from an armed, wake-enabled tick or a set command
  p_rise_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(armed) && $past(mode[MB_WAKE_EN]) && $past(tick_i))
                     || $past(cmd.wset));
endmodule

// File: tb/cal_alarm_unit_bench.sv
module cal_alarm_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [31:0] now_lo_i = '0, now_hi_i = '0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        irq_o, cnt_clear_o, cnt_hold_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cal_alarm_unit u_cal_alarm_unit (.*);

  // {alarm lo, alarm hi, mask lo, mask hi, now lo, now hi, expected}
  localparam logic [192:0] VEC [8] = '{
    {32'h0F1E2D3C, 32'h0, 32'hFFFFFFFF, 32'h0, 32'h0F1E2D3C, 32'h0, 1'b1},
    {32'h0F1E2D3C, 32'h0, 32'hFFFFFFFF, 32'h0, 32'h0F1E2D3D, 32'h0, 1'b0},
    {32'h0F1E2D3C, 32'h0, 32'hFFFFFF00, 32'h0, 32'h0F1E2D11, 32'h0, 1'b1},
    {32'h12345678, 32'h9, 32'h0,        32'h0, 32'hABCDEF01, 32'h7, 1'b1},
    {32'h0, 32'h00031807, 32'h0, 32'h0000FFFF, 32'h55, 32'h00051807, 1'b1},
    {32'h0, 32'h00031807, 32'h0, 32'h0000FFFF, 32'h55, 32'h00031808, 1'b0},
    {32'h0, 32'h0, 32'h00000001, 32'h0, 32'hFFFFFFFE, 32'h0, 1'b1},
    {32'h0, 32'h0, 32'h00000001, 32'h0, 32'h00000001, 32'h0, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk); @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic tick();
    tick_i = 1'b1;
    @(posedge clk); @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic prog(input logic [31:0] alo, ahi, mlo, mhi);
    wr(8'h0C, alo); wr(8'h10, ahi); wr(8'h14, mlo); wr(8'h18, mhi);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", irq_o, 1'b0);
    chk("R1 clear after reset", cnt_clear_o, 1'b0);
    chk("R1 hold after reset", cnt_hold_o, 1'b0);
    // R1: reset disarmed with wake off: zero masks match, tick must not fire
    tick();
    chk("R1 disarmed after reset", irq_o, 1'b0);

    wr(8'h04, 32'h2);
    wr(8'h00, 32'h4);
    foreach (VEC[i]) begin
      prog(VEC[i][192:161], VEC[i][160:129], VEC[i][128:97], VEC[i][96:65]);
      now_lo_i = VEC[i][64:33]; now_hi_i = VEC[i][32:1];
      tick();
      chk($sformatf("R2/R3/R4 vector %0d", i), irq_o, VEC[i][0]);
      wr(8'h00, 32'h100);
      chk("R8 wake clear", irq_o, 1'b0);
    end

    // R5: matching fields without tick
    prog(32'h01020304, 32'h0, 32'hFFFFFFFF, 32'h0);
    now_lo_i = 32'h01020304;
    repeat (4) @(negedge clk);
    chk("R5 no tick no irq", irq_o, 1'b0);

    // R7: wake disabled
    wr(8'h04, 32'h0);
    tick();
    chk("R7 wake disabled", irq_o, 1'b0);
    wr(8'h04, 32'h2);

    // R6: disarmed
    wr(8'h00, 32'h8);
    tick();
    chk("R6 disarmed", irq_o, 1'b0);
    wr(8'h00, 32'hC);
    tick();
    chk("R6 arm and disarm together", irq_o, 1'b0);
    wr(8'h00, 32'h4);
    tick();
    chk("R6 re-armed fires", irq_o, 1'b1);

    // R8/R11: level holds, hold request with continue clear
    repeat (3) @(negedge clk);
    chk("R8 level holds", irq_o, 1'b1);
    now_lo_i = 32'h0;
    tick();
    chk("R8 level holds over nonmatching tick", irq_o, 1'b1);
    chk("R11 hold without continue", cnt_hold_o, 1'b1);
    wr(8'h04, 32'hA);
    chk("R11 no hold with continue", cnt_hold_o, 1'b0);
    wr(8'h00, 32'h8);
    chk("R8 disarm clears", irq_o, 1'b0);

    // R9: set command while disarmed
    wr(8'h00, 32'h200);
    chk("R9 wake set", irq_o, 1'b1);
    wr(8'h00, 32'h100);
    chk("R9 cleared after set", irq_o, 1'b0);

    // R10: counter clear pulse
    wr(8'h04, 32'h6);
    wr(8'h00, 32'h4);
    now_lo_i = 32'h01020304;
    tick();
    chk("R10 pulse with irq", irq_o, 1'b1);
    chk("R10 pulse high", cnt_clear_o, 1'b1);
    @(negedge clk);
    chk("R10 pulse one cycle", cnt_clear_o, 1'b0);
    wr(8'h00, 32'h100);

    // R12: clear and firing tick together
    tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 8'h00; wr_data_i = 32'h100;
    @(posedge clk); @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    chk("R12 clear wins", irq_o, 1'b0);
    chk("R12 no pulse", cnt_clear_o, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule